// File: doc/BRIEF.md
# Isolated-Pin I2C Register Slave

This block lets a host on an I2C-compatible bus read and write an 8-bit register file. The bus clock is an input only. Serial data enters on one pin and leaves on a second pin. The second pin is open-drain: the block only pulls it low, and an external pull-up provides the high level. With data split across two pins, the bus can be carried across optocouplers. Both bus lines are oversampled by the system clock. The block detects START and STOP conditions and compares the 7-bit device address. The upper address bits come from a parameter. The four lower bits come from address pins, which are captured while reset is asserted.

A transfer has the following order:
1. START.
2. The address byte, which carries the read/write bit.
3. A command byte, which loads a register pointer.
4. Data bytes.

Each data byte moves through a one-cycle strobe port to the register file. After each byte the pointer advances by one, so a host can fetch a multi-byte value in a single burst. To read, the host writes the command byte, issues a repeated START, and then clocks out bytes. One register address is served inside the block: it returns the captured address pins, and writes to it are dropped.

Top module: `iso_i2c_regslave`

## Requirements
- R1: Address matching starts only after a START. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. After a STOP the output pin is released. An address byte clocked in without a preceding START gets no acknowledge.
- R2: The slave acknowledges an address byte only if all 7 address bits equal `{DEV_ADDR_BASE[6:4], captured pins}`. To acknowledge, it holds `sda_drive_low` high through the ninth SCL pulse. Any other address gets no acknowledge and produces no `reg_wr` or `reg_rd` strobe.
- R3: `addr_pins` is captured only while `rst_n` is low. A read of register address 8'h11 returns `{4'b0000, captured pins}`, and changing the pins later has no effect on that value or on address matching.
- R4: After a write address, the slave acknowledges the next byte and loads it into the register pointer, which appears on `reg_addr`.
- R5: For each data byte written, the slave acknowledges the byte and pulses `reg_wr` for exactly one cycle. During that cycle, `reg_addr` holds the pointer and `reg_wdata` holds the byte. The pointer then advances by one.
- R6: During a read, `reg_rd` pulses for one cycle with `reg_addr` equal to the pointer, and `reg_rdata` is sampled in that same cycle. The byte is shifted out MSB first, and the pointer then advances by one. The pointer survives a STOP.
- R7: In a read, the first byte is fetched when the address byte completes. Each later byte is fetched only when the master acknowledges the previous one. A master NACK releases the pin and ends the transfer with no further fetch.
- R8: A repeated START restarts address matching and leaves the register pointer unchanged.
- R9: A write to register address 8'h11 produces no `reg_wr` strobe, but the pointer still advances.
- R10: While reset is held and just after it, `sda_drive_low`, `reg_wr` and `reg_rd` are 0 and `reg_addr` is 0.
- R11: `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; address pins captured while low |
| scl_i | input | 1 | Bus clock line (input only) |
| sda_i | input | 1 | Serial data input line |
| sda_drive_low | output | 1 | Open-drain data output: 1 pulls the output line low |
| addr_pins | input | 4 | Low device-address bits, captured during reset |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data, valid while `reg_wr` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled in the cycle `reg_rd` is high |

## Verification
The hardest situation to reach from the ports is a pointer value that outlives a change of transfer direction. For example, a burst read must resume at exactly the register after the last fetched byte, or a repeated START must follow a single written byte. The bench reaches these situations with sequences that chain a command write, a data write, a repeated START and reads. It predicts every returned byte from an arithmetic pattern. A full sweep over all 128 address bytes, followed by a second reset with different address pins, shows that the pins are captured only during reset.

// File: rtl/iso_i2c_pkg.sv
package iso_i2c_pkg;

   localparam int BYTE_W = 8;
   localparam int DEV_W  = 7;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } link_state_t;

endpackage

// File: rtl/iso_i2c_sync.sv
module iso_i2c_sync #(
   parameter int   WIDTH   = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("iso_i2c_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("iso_i2c_sync: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d_async[gi]};
      end
      assign d_sync[gi] = chain[STAGES-1];
   end

endmodule

// File: rtl/iso_i2c_cond.sv
module iso_i2c_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_p, sda_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/iso_i2c_engine.sv
module iso_i2c_engine
   import iso_i2c_pkg::*;
#(
   parameter int             AW          = 8,
   parameter logic [AW-1:0]  STATUS_ADDR = AW'(8'h11)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [DEV_W-1:0]  dev_addr,
   input  logic [BYTE_W-1:0] status_byte,
   output logic              sda_drive_low,
   output logic [AW-1:0]     reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [BYTE_W-1:0] reg_rdata
);

   generate
      if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
         $error("iso_i2c_engine: AW must lie in 1..8");
      end
   endgenerate

   link_state_t       state;
   logic [2:0]        bitcnt;
   logic [BYTE_W-1:0] shreg, txbuf, txsh, wdata_q;
   logic [BYTE_W-1:0] newbyte;
   logic [AW-1:0]     ptr;
   logic              byte_full, addr_ok, is_read, mack;
   logic              wr_q, rd_q, drv;

   assign newbyte       = {shreg[BYTE_W-2:0], sda_s};
   assign reg_addr      = ptr;
   assign reg_wdata     = wdata_q;
   assign reg_rd        = rd_q;
   assign reg_wr        = wr_q && (ptr != STATUS_ADDR);
   assign sda_drive_low = drv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         txbuf     <= '0;
         txsh      <= '0;
         wdata_q   <= '0;
         ptr       <= '0;
         byte_full <= 1'b0;
         addr_ok   <= 1'b0;
         is_read   <= 1'b0;
         mack      <= 1'b0;
         wr_q      <= 1'b0;
         rd_q      <= 1'b0;
         drv       <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         if (rd_q) txbuf <= (ptr == STATUS_ADDR) ? status_byte : reg_rdata;
         if (rd_q || wr_q) ptr <= ptr + 1'b1;

         if (start_det) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            drv       <= 1'b0;
         end else if (stop_det) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            drv       <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_WR: begin
                  if (scl_rise && !byte_full) begin
                     shreg  <= newbyte;
                     bitcnt <= 3'(bitcnt + 1'b1);
                     if (bitcnt == 3'd7) begin
                        byte_full <= 1'b1;
                        case (state)
                           ST_ADDR: begin
                              addr_ok <= (newbyte[BYTE_W-1:1] == dev_addr);
                              is_read <= newbyte[0];
                              if ((newbyte[BYTE_W-1:1] == dev_addr) && newbyte[0])
                                 rd_q <= 1'b1;
                           end
                           ST_CMD: ptr <= newbyte[AW-1:0];
                           ST_WR: begin
                              wdata_q <= newbyte;
                              wr_q    <= 1'b1;
                           end
                           default: ;
                        endcase
                     end
                  end else if (scl_fall && byte_full) begin
                     byte_full <= 1'b0;
                     if (state == ST_ADDR && !addr_ok) begin
                        state <= ST_IDLE;
                     end else begin
                        drv <= 1'b1;
                        case (state)
                           ST_ADDR: state <= ST_ADDR_ACK;
                           ST_CMD:  state <= ST_CMD_ACK;
                           default: state <= ST_WR_ACK;
                        endcase
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (is_read) begin
                        drv    <= ~txbuf[BYTE_W-1];
                        txsh   <= {txbuf[BYTE_W-2:0], 1'b1};
                        bitcnt <= 3'd1;
                        state  <= ST_RD;
                     end else begin
                        drv   <= 1'b0;
                        state <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK, ST_WR_ACK: begin
                  if (scl_fall) begin
                     drv    <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bitcnt == 3'd0) begin
                        drv   <= 1'b0;
                        state <= ST_RD_ACK;
                     end else begin
                        drv    <= ~txsh[BYTE_W-1];
                        txsh   <= {txsh[BYTE_W-2:0], 1'b1};
                        bitcnt <= 3'(bitcnt + 1'b1);
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                     if (!sda_s) rd_q <= 1'b1;
                  end else if (scl_fall) begin
                     if (mack) begin
                        drv    <= ~txbuf[BYTE_W-1];
                        txsh   <= {txbuf[BYTE_W-2:0], 1'b1};
                        bitcnt <= 3'd1;
                        state  <= ST_RD;
                     end else begin
                        drv   <= 1'b0;
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R11: the two strobes are mutually exclusive
   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   // R5: a write strobe lasts one cycle
   assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   // R6: the pointer steps by one after each fetch
   assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> (reg_addr == $past(reg_addr) + 1'b1));

   // R2: the output pin moves only on an SCL fall or a bus condition
   assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> $past(scl_fall || start_det || stop_det));

   // R1: a STOP releases the output pin
   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_drive_low);

   // R8: a repeated START leaves the pointer alone
   assert_rstart_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !rd_q && !wr_q) |=> $stable(reg_addr));

endmodule

// File: rtl/iso_i2c_regslave.sv
module iso_i2c_regslave
   import iso_i2c_pkg::*;
#(
   parameter int               PIN_W         = 4,
   parameter logic [DEV_W-1:0] DEV_ADDR_BASE = 7'b101_0000,
   parameter int               SYNC_STAGES   = 2,
   parameter logic [7:0]       STATUS_ADDR   = 8'h11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_drive_low,
   input  logic [PIN_W-1:0] addr_pins,
   output logic [7:0]       reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_wr,
   output logic             reg_rd,
   input  logic [7:0]       reg_rdata
);

   localparam int HI_W = DEV_W - PIN_W;

   generate
      if (PIN_W < 1 || PIN_W > DEV_W - 1) begin : g_bad_pins
         $error("iso_i2c_regslave: PIN_W must lie in 1..6");
      end
   endgenerate

   logic [PIN_W-1:0]  pins_q;
   logic [1:0]        bus_s;
   logic              scl_rise, scl_fall, start_det, stop_det;
   logic [DEV_W-1:0]  dev_addr;
   logic [BYTE_W-1:0] status_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) pins_q <= addr_pins;
   end

   assign dev_addr    = {DEV_ADDR_BASE[DEV_W-1 -: HI_W], pins_q};
   assign status_byte = BYTE_W'(pins_q);

   iso_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({scl_i, sda_i}),
      .d_sync  (bus_s)
   );

   iso_i2c_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (bus_s[1]),
      .sda_s     (bus_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   iso_i2c_engine #(.AW(8), .STATUS_ADDR(STATUS_ADDR)) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_rise      (scl_rise),
      .scl_fall      (scl_fall),
      .start_det     (start_det),
      .stop_det      (stop_det),
      .sda_s         (bus_s[0]),
      .dev_addr      (dev_addr),
      .status_byte   (status_byte),
      .sda_drive_low (sda_drive_low),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_wr        (reg_wr),
      .reg_rd        (reg_rd),
      .reg_rdata     (reg_rdata)
   );

   // R3: captured pins hold steady outside reset
   assert_pins_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pins_q));

endmodule

// File: tb/iso_i2c_regslave_test.sv
module iso_i2c_regslave_test;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic [3:0] addr_pins = 4'hA;
   logic       sda_drive_low, reg_wr, reg_rd;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;

   logic [7:0] mem [256];
   int total = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   iso_i2c_regslave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .sda_drive_low(sda_drive_low), .addr_pins(addr_pins),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   function automatic logic [7:0] init_val(int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   function automatic logic [7:0] pat(int i);
      return 8'((8'hC3 ^ (i * 37)) & 255);
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
         end
         if (reg_rd) rd_cnt <= rd_cnt + 1;
         if (reg_wr && reg_rd) both_cnt <= both_cnt + 1;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic do_reset(logic [3:0] p);
      @(negedge clk);
      rst_n = 1'b0; addr_pins = p; scl = 1'b1; sda = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wq();
   endtask

   task automatic bus_start();
      if (!scl) begin
         sda = 1'b1; wq(); scl = 1'b1; wq();
      end
      sda = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda = 1'b0; wq(); scl = 1'b1; wq(); sda = 1'b1; wq(); wq();
   endtask

   task automatic bit_xfer(input logic b, output logic s);
      sda = b; wq(); scl = 1'b1; wq();
      s = ~sda_drive_low;
      wq(); scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
      bit_xfer(1'b1, s);
      ack = ~s;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, s);
         v[i] = s;
      end
      bit_xfer(~give_ack, s);
   endtask

   initial begin
      logic ack;
      logic [7:0] v;
      int w0, r0;

      // R10: reset state
      @(negedge clk); @(negedge clk);
      chk("R10 drive in reset", sda_drive_low, 0);
      chk("R10 wr/rd in reset", {reg_wr, reg_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 drive after reset", sda_drive_low, 0);
      chk("R10 addr after reset", reg_addr, 0);
      wq();

      // R2: address sweep, device address {101, A} = 5A
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         bus_stop();
         chk("R2 address match", ack, (a == 8'h5A) ? 1 : 0);
      end
      chk("R2 no strobes on mismatch", wr_cnt + rd_cnt, 0);

      // R1: address byte without START is ignored
      send_byte({7'h5A, 1'b0}, ack);
      chk("R1 no ack without start", ack, 0);
      bus_stop();
      chk("R1 released after stop", sda_drive_low, 0);

      // R4 / R5: write burst from 40h
      w0 = wr_cnt;
      bus_start();
      send_byte({7'h5A, 1'b0}, ack); chk("R5 addr ack", ack, 1);
      send_byte(8'h40, ack);         chk("R4 cmd ack", ack, 1);
      for (int i = 0; i < 6; i++) begin
         send_byte(pat(i), ack);
         chk("R5 data ack", ack, 1);
      end
      bus_stop();
      chk("R5 write count", wr_cnt - w0, 6);
      for (int i = 0; i < 6; i++) chk("R5 written data", mem[8'h40 + i], pat(i));

      // R6 / R7 / R8: command, repeated START, burst read
      r0 = rd_cnt;
      bus_start();
      send_byte({7'h5A, 1'b0}, ack);
      send_byte(8'h40, ack);
      bus_start();
      send_byte({7'h5A, 1'b1}, ack); chk("R8 read addr ack", ack, 1);
      for (int i = 0; i < 6; i++) begin
         read_byte(i != 5, v);
         chk("R6 burst read data", v, pat(i));
      end
      chk("R7 released after nack", sda_drive_low, 0);
      bus_stop();
      chk("R7 fetch count", rd_cnt - r0, 6);

      // R6: pointer continues after STOP (next is 46h)
      bus_start();
      send_byte({7'h5A, 1'b1}, ack);
      read_byte(1'b0, v);
      bus_stop();
      chk("R6 pointer persists", v, init_val(8'h46));

      // R8: write one byte at 20h then repeated START read gives 21h
      bus_start();
      send_byte({7'h5A, 1'b0}, ack);
      send_byte(8'h20, ack);
      send_byte(8'h5E, ack);
      bus_start();
      send_byte({7'h5A, 1'b1}, ack);
      read_byte(1'b0, v);
      bus_stop();
      chk("R8 write landed", mem[8'h20], 8'h5E);
      chk("R8 pointer kept over restart", v, init_val(8'h21));

      // R3: status register returns latched pins
      bus_start();
      send_byte({7'h5A, 1'b0}, ack);
      send_byte(8'h11, ack);
      bus_start();
      send_byte({7'h5A, 1'b1}, ack);
      read_byte(1'b0, v);
      bus_stop();
      chk("R3 status value", v, 8'h0A);

      // R9: write to status address is dropped, pointer advances
      w0 = wr_cnt;
      bus_start();
      send_byte({7'h5A, 1'b0}, ack);
      send_byte(8'h11, ack);
      send_byte(8'hFF, ack); chk("R9 ack on status write", ack, 1);
      send_byte(8'h77, ack);
      bus_stop();
      chk("R9 strobe count", wr_cnt - w0, 1);
      chk("R9 status untouched", mem[8'h11], init_val(8'h11));
      chk("R9 next register", mem[8'h12], 8'h77);

      // R3: pins changed without reset have no effect
      @(negedge clk); addr_pins = 4'h3;
      bus_start(); send_byte({7'h5A, 1'b0}, ack); bus_stop();
      chk("R3 old address still matches", ack, 1);
      bus_start(); send_byte({7'h53, 1'b0}, ack); bus_stop();
      chk("R3 new pins ignored", ack, 0);
      bus_start();
      send_byte({7'h5A, 1'b0}, ack);
      send_byte(8'h11, ack);
      bus_start();
      send_byte({7'h5A, 1'b1}, ack);
      read_byte(1'b0, v);
      bus_stop();
      chk("R3 status unchanged", v, 8'h0A);

      // R3: new pins take effect after reset
      do_reset(4'h3);
      chk("R10 addr after second reset", reg_addr, 0);
      bus_start(); send_byte({7'h5A, 1'b0}, ack); bus_stop();
      chk("R3 old address dropped", ack, 0);
      bus_start();
      send_byte({7'h53, 1'b0}, ack); chk("R3 new address ack", ack, 1);
      send_byte(8'h11, ack);
      bus_start();
      send_byte({7'h53, 1'b1}, ack);
      read_byte(1'b0, v);
      bus_stop();
      chk("R3 status after reset", v, 8'h03);

      chk("R11 strobes exclusive", both_cnt, 0);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule